// File: doc/BRIEF.md
# PHY Register Access Sequencer

This block performs indirect reads and writes of 16-bit registers inside a serdes PHY that is reachable only through one control word (driven by the block) and one status word (sampled by the block). A host issues a single-cycle start with an address, write data and a read/write select. The sequencer then walks the PHY through its phases, one after another. An address-capture phase comes first. A write then runs a data-capture phase and a write-strobe phase. A read runs a read-strobe phase instead. Each phase is a four-phase request/acknowledge handshake: the request goes high, the acknowledge rises, the request falls, and the acknowledge falls.

Every acknowledge wait is bounded. The acknowledge is sampled once per poll interval, and a parameterised clock prescaler sets that interval. The number of samples is capped by a retry limit. If the expected level never appears, the access is abandoned, the control word is cleared, and done is reported together with an error. A read returns the low half of the status word, captured at the moment the acknowledge of the read strobe is seen high.

Top module: `phy_acc_seq`

## Requirements
- R1: After reset, the control word is 0 and rsp_done, rsp_err and busy are all 0.
- R2: Control word layout: bits 15:0 carry the address or the data. Bit 16 is capture-address, bit 17 is capture-data, bit 18 is the write strobe and bit 19 is the read strobe. At most one of bits 19:16 is high at any time.
- R3: The address phase drives the address alone, then the address with bit 16 set until the acknowledge (status bit 16) is seen high, then the address alone until the acknowledge is seen low.
- R4: A write follows the address phase with the data alone, then the data with bit 17 set (wait for ack high), then the data alone (wait for ack low), then bit 18 alone (wait for ack high), then the data alone (wait for ack low), and finally a control word of 0.
- R5: A read follows the address phase with bit 19 alone (wait for ack high) and then a control word of 0 (wait for ack low). rsp_rdata is status bits 15:0 as sampled when the acknowledge was seen high.
- R6: In each wait, the acknowledge is sampled in the first cycle of the wait state and then every PRESCALE cycles, with at most POLL_LIMIT samples. If the address-capture wait never sees the acknowledge, done arrives 2+(POLL_LIMIT-1)*PRESCALE cycles after the start edge.
- R7: A wait that exhausts its samples abandons the access: no later phase is issued, the control word goes to 0, and rsp_done and rsp_err are asserted together.
- R8: A start seen while idle makes busy high from the next cycle. A start seen while busy is ignored and changes neither the control word sequence nor the PHY contents.
- R9: rsp_done is a one-cycle pulse after which the block is idle. rsp_err is high only with rsp_done, and is low for an access that completes normally, even one that follows a failed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Start an access (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | DW | PHY register address |
| req_wdata | input | DW | Write data |
| rsp_rdata | output | DW | Read data of the last successful read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Timeout flag, valid with rsp_done |
| busy | output | 1 | Access in progress |
| phy_ctrl | output | DW+4 | Control word to the PHY |
| phy_stat | input | DW+1 | Status word from the PHY (ack in top bit) |

## Verification
A wrong sequencer state shows up at once at the control word. A skipped, repeated or reordered phase changes the next control word value, and that change is visible one cycle after the faulty transition. A wrong poll counter or prescaler shows up only at the end of a wait: a timeout arrives a different number of cycles after start, or a slow but valid acknowledge is missed. Stale error or read-data state shows up on the next rsp_done, so it can stay hidden until another access completes.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
   typedef enum logic [3:0] {
      S_IDLE = 4'd0,
      S_ADRV = 4'd1,
      S_ACAP = 4'd2,
      S_AREL = 4'd3,
      S_DDRV = 4'd4,
      S_DCAP = 4'd5,
      S_DREL = 4'd6,
      S_WSTB = 4'd7,
      S_WREL = 4'd8,
      S_RSTB = 4'd9,
      S_RREL = 4'd10,
      S_FIN  = 4'd11
   } seq_state_t;

   // strobe offsets above the payload field
   localparam int OFS_CAP_ADDR = 0;
   localparam int OFS_CAP_DATA = 1;
   localparam int OFS_WR       = 2;
   localparam int OFS_RD       = 3;
endpackage

// File: rtl/phy_poll_timer.sv
module phy_poll_timer #(
   parameter int PRESCALE   = 100,
   parameter int POLL_LIMIT = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick,
   output logic last
);
   localparam int AW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
   localparam logic [AW-1:0] ATT_MAX = AW'(POLL_LIMIT - 1);

   logic [AW-1:0] att;

   generate
      if (PRESCALE == 1) begin : g_every_cycle
         assign tick = 1'b1;
      end else begin : g_divided
         localparam int PW = $clog2(PRESCALE);
         localparam logic [PW-1:0] PRE_MAX = PW'(PRESCALE - 1);
         logic [PW-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pre <= '0;
            else if (restart)          pre <= '0;
            else if (pre == PRE_MAX)   pre <= '0;
            else                       pre <= pre + 1'b1;
         end
         assign tick = (pre == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       att <= '0;
      else if (restart)                 att <= '0;
      else if (tick && att != ATT_MAX)  att <= att + 1'b1;
   end

   assign last = (att == ATT_MAX);
endmodule

// File: rtl/phy_ctrl_pack.sv
module phy_ctrl_pack
   import phy_seq_pkg::*;
#(
   parameter int DW = 16
) (
   input  seq_state_t       state,
   input  logic [DW-1:0]    addr,
   input  logic [DW-1:0]    data,
   output logic [DW+3:0]    ctrl
);
   localparam int CW = DW + 4;
   localparam logic [CW-1:0] M_CA = CW'(1) << (DW + OFS_CAP_ADDR);
   localparam logic [CW-1:0] M_CD = CW'(1) << (DW + OFS_CAP_DATA);
   localparam logic [CW-1:0] M_WR = CW'(1) << (DW + OFS_WR);
   localparam logic [CW-1:0] M_RD = CW'(1) << (DW + OFS_RD);

   logic [CW-1:0] a_ext, d_ext;
   assign a_ext = CW'(addr);
   assign d_ext = CW'(data);

   always_comb begin
      case (state)
         S_ADRV, S_AREL:         ctrl = a_ext;
         S_ACAP:                 ctrl = a_ext | M_CA;
         S_DDRV, S_DREL, S_WREL: ctrl = d_ext;
         S_DCAP:                 ctrl = d_ext | M_CD;
         S_WSTB:                 ctrl = M_WR;
         S_RSTB:                 ctrl = M_RD;
         default:                ctrl = '0;
      endcase
   end
endmodule

// File: rtl/phy_acc_seq.sv
module phy_acc_seq
   import phy_seq_pkg::*;
#(
   parameter int DW         = 16,
   parameter int PRESCALE   = 100,
   parameter int POLL_LIMIT = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_start,
   input  logic            req_write,
   input  logic [DW-1:0]   req_addr,
   input  logic [DW-1:0]   req_wdata,
   output logic [DW-1:0]   rsp_rdata,
   output logic            rsp_done,
   output logic            rsp_err,
   output logic            busy,
   output logic [DW+3:0]   phy_ctrl,
   input  logic [DW:0]     phy_stat
);
   generate
      if (DW < 1)         begin : g_bad_dw   $error("DW must be at least 1");         end
      if (PRESCALE < 1)   begin : g_bad_pre  $error("PRESCALE must be at least 1");   end
      if (POLL_LIMIT < 1) begin : g_bad_lim  $error("POLL_LIMIT must be at least 1"); end
   endgenerate

   seq_state_t    state, state_n, adv;
   logic [DW-1:0] addr_q, data_q, rdata_q;
   logic          wr_q, err_q;
   logic          wait_st, want_hi, cap_rd, tmo;
   logic          tick, last, ack;

   assign ack = phy_stat[DW];

   phy_poll_timer #(.PRESCALE(PRESCALE), .POLL_LIMIT(POLL_LIMIT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (state_n != state),
      .tick    (tick),
      .last    (last)
   );

   phy_ctrl_pack #(.DW(DW)) u_pack (
      .state (state),
      .addr  (addr_q),
      .data  (data_q),
      .ctrl  (phy_ctrl)
   );

   always_comb begin
      state_n = state;
      adv     = state;
      wait_st = 1'b0;
      want_hi = 1'b0;
      cap_rd  = 1'b0;
      tmo     = 1'b0;
      case (state)
         S_IDLE: if (req_start) state_n = S_ADRV;
         S_ADRV: state_n = S_ACAP;
         S_ACAP: begin wait_st = 1'b1; want_hi = 1'b1; adv = S_AREL; end
         S_AREL: begin wait_st = 1'b1; adv = wr_q ? S_DDRV : S_RSTB; end
         S_DDRV: state_n = S_DCAP;
         S_DCAP: begin wait_st = 1'b1; want_hi = 1'b1; adv = S_DREL; end
         S_DREL: begin wait_st = 1'b1; adv = S_WSTB; end
         S_WSTB: begin wait_st = 1'b1; want_hi = 1'b1; adv = S_WREL; end
         S_WREL: begin wait_st = 1'b1; adv = S_FIN; end
         S_RSTB: begin wait_st = 1'b1; want_hi = 1'b1; adv = S_RREL; end
         S_RREL: begin wait_st = 1'b1; adv = S_FIN; end
         S_FIN:  state_n = S_IDLE;
         default: state_n = S_IDLE;
      endcase
      if (wait_st && tick) begin
         if (ack == want_hi) begin
            state_n = adv;
            cap_rd  = (state == S_RSTB);
         end else if (last) begin
            state_n = S_FIN;
            tmo     = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
         wr_q    <= 1'b0;
         err_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         state <= state_n;
         if (state == S_IDLE && req_start) begin
            addr_q <= req_addr;
            data_q <= req_wdata;
            wr_q   <= req_write;
            err_q  <= 1'b0;
         end else if (tmo) begin
            err_q  <= 1'b1;
         end
         if (cap_rd) rdata_q <= phy_stat[DW-1:0];
      end
   end

   assign busy      = (state != S_IDLE);
   assign rsp_done  = (state == S_FIN);
   assign rsp_err   = rsp_done & err_q;
   assign rsp_rdata = rdata_q;
endmodule

// File: rtl/phy_acc_seq_chk.sv
module phy_acc_seq_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_start,
   input logic          busy,
   input logic          rsp_done,
   input logic          rsp_err,
   input logic [DW+3:0] phy_ctrl
);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> phy_ctrl == '0);

   a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(phy_ctrl[DW+3:DW]));

   a_r4_strobe_bare: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_ctrl[DW+2] || phy_ctrl[DW+3]) |-> phy_ctrl[DW-1:0] == '0);

   a_r7_clear_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> phy_ctrl == '0);

   a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_start) |=> busy);

   a_r8_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_start));

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> (!rsp_done && !busy));

   a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_done);
endmodule

bind phy_acc_seq phy_acc_seq_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_start (req_start),
   .busy      (busy),
   .rsp_done  (rsp_done),
   .rsp_err   (rsp_err),
   .phy_ctrl  (phy_ctrl)
);

// File: tb/sim_phy_acc_seq.sv
module sim_phy_acc_seq;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int PS = 4;
   localparam int PL = 10;
   localparam int CW = DW + 4;
   localparam logic [CW-1:0] B_CA = CW'(1) << 16;
   localparam logic [CW-1:0] B_CD = CW'(1) << 17;
   localparam logic [CW-1:0] B_WS = CW'(1) << 18;
   localparam logic [CW-1:0] B_RS = CW'(1) << 19;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_start = 1'b0, req_write = 1'b0;
   logic [DW-1:0] req_addr = '0, req_wdata = '0, rsp_rdata;
   logic rsp_done, rsp_err, busy;
   logic [CW-1:0] phy_ctrl;
   logic [DW:0]   phy_stat;

   int tests = 0, fails = 0;

   // bench PHY model
   logic [15:0] pmem [16];
   logic [15:0] refm [16];
   logic [15:0] paddr = '0, pdata = '0, rd_val = '0;
   logic        ack_m = 1'b0;
   int          dcnt = 0, ack_dly = 3;
   bit          mute = 0, stuck = 0;
   logic [CW-1:0] pc_prev = '0;

   // expected control word trace
   logic [CW-1:0] expq [$];
   logic [CW-1:0] last_push = '0, last_seen = '0, e_t;

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_acc_seq #(.DW(DW), .PRESCALE(PS), .POLL_LIMIT(PL)) u0 (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .busy(busy),
      .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
   );

   assign phy_stat = {ack_m, rd_val};

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void push(input logic [CW-1:0] v);
      if (v != last_push) begin
         expq.push_back(v);
         last_push = v;
      end
   endfunction

   function automatic void wseq(input logic [15:0] a, input logic [15:0] d);
      push(CW'(a)); push(CW'(a) | B_CA); push(CW'(a));
      push(CW'(d)); push(CW'(d) | B_CD); push(CW'(d));
      push(B_WS); push(CW'(d)); push('0);
   endfunction

   function automatic void rseq(input logic [15:0] a);
      push(CW'(a)); push(CW'(a) | B_CA); push(CW'(a));
      push(B_RS); push('0);
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (mute)       ack_m = 1'b0;
         else if (stuck) ack_m = 1'b1;
         else if ((|phy_ctrl[19:16]) != ack_m) begin
            dcnt++;
            if (dcnt >= ack_dly) begin ack_m = |phy_ctrl[19:16]; dcnt = 0; end
         end else dcnt = 0;
         if (phy_ctrl[16] && !pc_prev[16]) paddr = phy_ctrl[15:0];
         if (phy_ctrl[17] && !pc_prev[17]) pdata = phy_ctrl[15:0];
         if (phy_ctrl[18] && !pc_prev[18]) pmem[paddr[3:0]] = pdata;
         if (phy_ctrl[19] && !pc_prev[19]) rd_val = pmem[paddr[3:0]];
         pc_prev = phy_ctrl;
      end
   end

   always @(negedge clk) begin
      if (rst_n && phy_ctrl != last_seen) begin
         if (expq.size() == 0) chk(1'b0, "R2 unexpected control word step", 32'(phy_ctrl), 32'(last_seen));
         else begin
            e_t = expq.pop_front();
            chk(phy_ctrl == e_t, "R2/R3/R4/R5 control word step", 32'(phy_ctrl), 32'(e_t));
         end
         last_seen = phy_ctrl;
      end
   end

   task automatic run(input bit wr, input logic [15:0] a, input logic [15:0] d, input bit poke,
                      output int lat, output bit er, output logic [15:0] rd);
      @(negedge clk);
      req_write = wr; req_addr = a; req_wdata = d; req_start = 1'b1;
      @(posedge clk); @(negedge clk);
      req_start = 1'b0;
      chk(busy == 1'b1, "R8 busy after accepted start", 32'(busy), 32'd1);
      lat = 0;
      while (!rsp_done && lat < 2000) begin
         if (poke && lat == 4) begin
            req_start = 1'b1; req_write = 1'b1; req_addr = 16'h0007; req_wdata = 16'h5555;
         end else req_start = 1'b0;
         @(posedge clk); @(negedge clk);
         lat++;
      end
      req_start = 1'b0;
      chk(lat < 2000, "R9 done never arrived", 32'(lat), 32'd0);
      er = rsp_err; rd = rsp_rdata;
      chk(phy_ctrl == '0, "R7 control word clear at done", 32'(phy_ctrl), 32'd0);
      @(posedge clk); @(negedge clk);
      chk(!rsp_done && !busy && !rsp_err, "R9 single done then idle",
          {29'd0, rsp_done, rsp_err, busy}, 32'd0);
      chk(expq.size() == 0, "R2 control trace incomplete", 32'(expq.size()), 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      tests++; fails++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int lat; bit er; logic [15:0] rd;
      for (int i = 0; i < 16; i++) begin
         pmem[i] = 16'h0A00 + 16'(i) * 16'h0101;
         refm[i] = pmem[i];
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(phy_ctrl == '0, "R1 control word after reset", 32'(phy_ctrl), 32'd0);
      chk(!rsp_done, "R1 done after reset", 32'(rsp_done), 32'd0);
      chk(!rsp_err, "R1 err after reset", 32'(rsp_err), 32'd0);
      chk(!busy, "R1 busy after reset", 32'(busy), 32'd0);

      // R3 R4: plain write
      wseq(16'h0003, 16'h1234); refm[3] = 16'h1234;
      run(1'b1, 16'h0003, 16'h1234, 1'b0, lat, er, rd);
      chk(!er, "R4 write error flag", 32'(er), 32'd0);
      chk(pmem[3] == 16'h1234, "R4 PHY register written", 32'(pmem[3]), 32'h1234);

      // R5: read back
      rseq(16'h0003);
      run(1'b0, 16'h0003, 16'h0000, 1'b0, lat, er, rd);
      chk(!er, "R5 read error flag", 32'(er), 32'd0);
      chk(rd == refm[3], "R5 read data", 32'(rd), 32'(refm[3]));

      // R8: start while busy is ignored
      wseq(16'h0005, 16'hBEEF); refm[5] = 16'hBEEF;
      run(1'b1, 16'h0005, 16'hBEEF, 1'b1, lat, er, rd);
      chk(pmem[7] == refm[7], "R8 ignored start left PHY untouched", 32'(pmem[7]), 32'(refm[7]));
      rseq(16'h0007);
      run(1'b0, 16'h0007, 16'h0000, 1'b0, lat, er, rd);
      chk(rd == refm[7], "R8 read of address named by ignored start", 32'(rd), 32'(refm[7]));
      rseq(16'h0005);
      run(1'b0, 16'h0005, 16'h0000, 1'b0, lat, er, rd);
      chk(rd == 16'hBEEF, "R5 read after write", 32'(rd), 32'hBEEF);

      // R6 R7: no acknowledge at all
      mute = 1;
      push(16'h0009); push(CW'(16'h0009) | B_CA); push('0);
      run(1'b1, 16'h0009, 16'h7777, 1'b0, lat, er, rd);
      chk(er, "R7 timeout reports error", 32'(er), 32'd1);
      chk(lat == 2 + (PL - 1) * PS, "R6 timeout latency", 32'(lat), 32'(2 + (PL - 1) * PS));
      mute = 0;
      repeat (5) @(negedge clk);
      chk(pmem[9] == refm[9], "R7 aborted write left PHY untouched", 32'(pmem[9]), 32'(refm[9]));

      // R7: acknowledge never falls
      stuck = 1;
      push(16'h0002); push(CW'(16'h0002) | B_CA); push(16'h0002); push('0);
      run(1'b0, 16'h0002, 16'h0000, 1'b0, lat, er, rd);
      chk(er, "R7 release timeout reports error", 32'(er), 32'd1);
      stuck = 0;
      repeat (10) @(negedge clk);

      // R9: next good access carries no error
      rseq(16'h0009);
      run(1'b0, 16'h0009, 16'h0000, 1'b0, lat, er, rd);
      chk(!er, "R9 error cleared on next access", 32'(er), 32'd0);
      chk(rd == refm[9], "R5 read data after error", 32'(rd), 32'(refm[9]));

      // R6: slow acknowledge inside the window
      ack_dly = 30;
      wseq(16'h000A, 16'h0F0F); refm[10] = 16'h0F0F;
      run(1'b1, 16'h000A, 16'h0F0F, 1'b0, lat, er, rd);
      chk(!er, "R6 slow ack within poll window", 32'(er), 32'd0);
      chk(pmem[10] == 16'h0F0F, "R6 slow write landed", 32'(pmem[10]), 32'h0F0F);

      // R6: acknowledge slower than the window
      ack_dly = 50;
      push(16'h000A); push(CW'(16'h000A) | B_CA); push('0);
      run(1'b0, 16'h000A, 16'h0000, 1'b0, lat, er, rd);
      chk(er, "R6 ack beyond poll window times out", 32'(er), 32'd1);
      ack_dly = 3;
      repeat (60) @(negedge clk);

      rseq(16'h000A);
      run(1'b0, 16'h000A, 16'h0000, 1'b0, lat, er, rd);
      chk(rd == 16'h0F0F && !er, "R5 final read", 32'(rd), 32'h0F0F);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule